// File: doc/BRIEF.md
# Two-Level Inclusive Cache Event Sequencer

This block keeps tag state for a small first-level cache and a larger second-level cache and runs one memory access at a time through both. For each access it reports a pair of event codes, one per level. A hit in the first level settles the access there. A read miss looks up the second level and then fills the first level, and a write miss is passed down as a write. Memory appears only as a strobe that carries an address and a read/write flag. No data moves through the block.

Both levels are write-back. Neither level allocates on a write miss. Placement prefers the lowest-numbered empty way. When every way of a set is valid, a per-set round-robin pointer picks the victim. A dirty first-level victim is written into the second level after the fill. The second level always holds every valid first-level block: when it evicts a block, the first-level lines inside that block are invalidated, and their dirty state is folded into the single memory writeback.

The request port is valid/ready. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` then stays low until the response cycle has ended. The response has no back-pressure: `resp_valid` is high for exactly one cycle.

Top module: `cache_seq`

## Requirements
- R1: `req_ready` is high while the block is idle, including straight after reset. It goes low on the edge that accepts a request and stays low through the response cycle. `resp_valid` is high for exactly one cycle per accepted request.
- R2: The 3-bit event codes are 0 = no access, 1 = read hit, 2 = read miss, 3 = write hit, 4 = write miss. When the first level hits, the second-level code is 0.
- R3: A first-level read miss reads the second level, which reports 1 on a hit or 2 on a miss. On a second-level miss, one memory read strobe is issued at the request address with the second-level block offset bits cleared, and the block is installed in both levels.
- R4: A first-level write hit only marks the line dirty. A first-level write miss writes the second level, which reports 3 and marks its line dirty on a hit. On a second-level write miss, the level reports 4 and issues one memory write strobe at the request address, and neither level allocates.
- R5: A fill goes to the lowest-numbered empty way of its set. If the set is full, the fill goes to the way named by that set's round-robin pointer. The pointer starts at 0, wraps after WAYS-1, and advances only when a valid line is evicted.
- R6: When a first-level fill evicts a dirty line, that line is written into the second level. A hit there marks the line dirty, and a miss issues a memory write strobe instead. The reported code pair is not changed by this writeback.
- R7: When the second level evicts a valid block, every first-level line inside that block is invalidated. One memory write strobe is issued if the evicted block or any of those lines was dirty.
- R8: `resp_valid` rises N edges after the accept edge. N is 1 for a first-level hit and 2 for a write miss. For a read miss, N is 3, plus 1 if the second level misses, plus L2_BLK/L1_BLK if that miss evicts a valid block, plus 1 if the first-level victim is dirty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block is idle and can take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Byte address of the access |
| resp_valid | output | 1 | One-cycle strobe carrying the code pair |
| resp_l1 | output | 3 | First-level event code |
| resp_l2 | output | 3 | Second-level event code |
| mem_valid | output | 1 | Memory request strobe |
| mem_write | output | 1 | 1 = memory write, 0 = memory fetch |
| mem_addr | output | AW | Memory request address |

## Verification
Each response is due a fixed number of edges after its accept edge, and that number depends only on which path the access takes (R8). The bench drives inputs and samples outputs at falling edges. After acceptance it counts rising edges until `resp_valid` appears, logging memory strobes and checking that `req_ready` stays low on each of those cycles. A reference model in the bench works out the code pair, the edge count, the memory strobe counts and the fetch address before each access. The observed values are compared against it, and a long pseudo-random sweep over a 1 KiB window is checked the same way.

// File: rtl/cseq_pkg.sv
package cseq_pkg;
  typedef enum logic [2:0] {
    EV_NONE    = 3'd0,
    EV_RD_HIT  = 3'd1,
    EV_RD_MISS = 3'd2,
    EV_WR_HIT  = 3'd3,
    EV_WR_MISS = 3'd4
  } ev_t;

  typedef enum logic [1:0] {
    TOP_NONE,
    TOP_FILL,
    TOP_DIRTY,
    TOP_INVAL
  } tag_op_t;
endpackage

// File: rtl/cseq_way_pick.sv
module cseq_way_pick #(
  parameter int WAYS = 2,
  parameter int WW   = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic [WAYS-1:0] valid,
  input  logic [WW-1:0]   rr,
  output logic [WW-1:0]   way,
  output logic            evict
);
  // lowest empty way wins; otherwise the round-robin pointer names the victim
  always_comb begin
    way   = rr;
    evict = 1'b1;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (!valid[w]) begin
        way   = WW'(w);
        evict = 1'b0;
      end
    end
  end
endmodule

// File: rtl/cseq_tag_array.sv
module cseq_tag_array
  import cseq_pkg::*;
#(
  parameter int AW        = 32,
  parameter int SETS      = 4,
  parameter int WAYS      = 2,
  parameter int BLK_BYTES = 4,
  parameter int WW        = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] lk_addr,
  input  tag_op_t       op,
  output logic          hit,
  output logic          hit_dirty,
  output logic          vic_valid,
  output logic          vic_dirty,
  output logic [AW-1:0] vic_addr
);
  localparam int OW = $clog2(BLK_BYTES);
  localparam int IW = $clog2(SETS);
  localparam int TW = AW - OW - IW;

  logic [TW-1:0]   tag_q   [SETS][WAYS];
  logic [WAYS-1:0] valid_q [SETS];
  logic [WAYS-1:0] dirty_q [SETS];
  logic [WW-1:0]   rr_q    [SETS];

  logic [IW-1:0]   set_idx;
  logic [TW-1:0]   tag_in;
  logic [WAYS-1:0] hit_vec;
  logic [WW-1:0]   hit_way;
  logic [WW-1:0]   vic_way;
  logic            vic_evict;

  assign set_idx = lk_addr[OW+IW-1:OW];
  assign tag_in  = lk_addr[AW-1:OW+IW];

  always_comb begin
    hit_vec = '0;
    hit_way = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (valid_q[set_idx][w] && (tag_q[set_idx][w] == tag_in)) begin
        hit_vec[w] = 1'b1;
        hit_way    = WW'(w);
      end
    end
  end

  assign hit       = |hit_vec;
  assign hit_dirty = hit && dirty_q[set_idx][hit_way];

  cseq_way_pick #(.WAYS(WAYS), .WW(WW)) u_pick (
    .valid (valid_q[set_idx]),
    .rr    (rr_q[set_idx]),
    .way   (vic_way),
    .evict (vic_evict)
  );

  assign vic_valid = vic_evict;
  assign vic_dirty = vic_evict && dirty_q[set_idx][vic_way];
  assign vic_addr  = AW'({tag_q[set_idx][vic_way], set_idx}) << OW;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) begin
        valid_q[s] <= '0;
        dirty_q[s] <= '0;
        rr_q[s]    <= '0;
      end
    end else begin
      case (op)
        TOP_FILL: begin
          valid_q[set_idx][vic_way] <= 1'b1;
          dirty_q[set_idx][vic_way] <= 1'b0;
          if (vic_evict)
            rr_q[set_idx] <= (rr_q[set_idx] == WW'(WAYS - 1)) ? '0 : rr_q[set_idx] + 1'b1;
        end
        TOP_DIRTY: dirty_q[set_idx][hit_way] <= 1'b1;
        TOP_INVAL: begin
          valid_q[set_idx][hit_way] <= 1'b0;
          dirty_q[set_idx][hit_way] <= 1'b0;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (op == TOP_FILL) tag_q[set_idx][vic_way] <= tag_in;
  end

  AST_FILL_ONLY_ON_MISS: assert property (@(posedge clk) disable iff (!rst_n)
    (op == TOP_FILL) |-> !hit); // R3
  AST_DIRTY_NEEDS_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    (op == TOP_DIRTY) |-> hit); // R4
  AST_INVAL_NEEDS_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    (op == TOP_INVAL) |-> hit); // R7
endmodule

// File: rtl/cache_seq.sv
module cache_seq
  import cseq_pkg::*;
#(
  parameter int AW      = 32,
  parameter int L1_SETS = 4,
  parameter int L1_WAYS = 2,
  parameter int L1_BLK  = 4,
  parameter int L2_SETS = 8,
  parameter int L2_WAYS = 4,
  parameter int L2_BLK  = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  output logic          resp_valid,
  output logic [2:0]    resp_l1,
  output logic [2:0]    resp_l2,
  output logic          mem_valid,
  output logic          mem_write,
  output logic [AW-1:0] mem_addr
);
  localparam int L1OFF = $clog2(L1_BLK);
  localparam int L2OFF = $clog2(L2_BLK);
  localparam int SUB   = L2_BLK / L1_BLK;
  localparam int SW    = (SUB > 1) ? $clog2(SUB) : 1;

  typedef enum logic [3:0] {
    S_IDLE, S_L1, S_L2RD, S_L2WR, S_INV, S_L2FILL, S_L1FILL, S_WB, S_DONE
  } st_t;

  st_t           st;
  logic          wr_q;
  logic [AW-1:0] addr_q;
  ev_t           ev1_q, ev2_q;
  logic [AW-1:0] l2v_addr_q;
  logic          l2v_evict_q;
  logic          l2v_dirty_q;
  logic [SW-1:0] sub_q;
  logic [AW-1:0] l1v_addr_q;

  logic [AW-1:0] l1_addr, l2_addr;
  tag_op_t       l1_op, l2_op;
  logic          l1_hit, l1_hit_dirty, l1_vic_valid, l1_vic_dirty;
  logic          l2_hit, l2_hit_dirty, l2_vic_valid, l2_vic_dirty;
  logic [AW-1:0] l1_vic_addr, l2_vic_addr;

  assign l1_addr = (st == S_INV) ? (l2v_addr_q | (AW'(sub_q) << L1OFF)) : addr_q;
  assign l2_addr = (st == S_WB) ? l1v_addr_q : addr_q;

  cseq_tag_array #(.AW(AW), .SETS(L1_SETS), .WAYS(L1_WAYS), .BLK_BYTES(L1_BLK)) u_l1 (
    .clk, .rst_n, .lk_addr(l1_addr), .op(l1_op),
    .hit(l1_hit), .hit_dirty(l1_hit_dirty),
    .vic_valid(l1_vic_valid), .vic_dirty(l1_vic_dirty), .vic_addr(l1_vic_addr)
  );

  cseq_tag_array #(.AW(AW), .SETS(L2_SETS), .WAYS(L2_WAYS), .BLK_BYTES(L2_BLK)) u_l2 (
    .clk, .rst_n, .lk_addr(l2_addr), .op(l2_op),
    .hit(l2_hit), .hit_dirty(l2_hit_dirty),
    .vic_valid(l2_vic_valid), .vic_dirty(l2_vic_dirty), .vic_addr(l2_vic_addr)
  );

  // tag updates per state
  always_comb begin
    l1_op = TOP_NONE;
    l2_op = TOP_NONE;
    case (st)
      S_L1:     if (l1_hit && wr_q) l1_op = TOP_DIRTY;
      S_L2WR:   if (l2_hit) l2_op = TOP_DIRTY;
      S_INV:    if (l1_hit) l1_op = TOP_INVAL;
      S_L2FILL: l2_op = TOP_FILL;
      S_L1FILL: l1_op = TOP_FILL;
      S_WB:     if (l2_hit) l2_op = TOP_DIRTY;
      default: ;
    endcase
  end

  // memory strobe
  always_comb begin
    mem_valid = 1'b0;
    mem_write = 1'b0;
    mem_addr  = addr_q;
    case (st)
      S_L2WR: if (!l2_hit) begin
        mem_valid = 1'b1;
        mem_write = 1'b1;
      end
      S_L2RD: if (!l2_hit) begin
        mem_valid = 1'b1;
        mem_addr  = (addr_q >> L2OFF) << L2OFF;
      end
      S_L2FILL: if (l2v_evict_q && l2v_dirty_q) begin
        mem_valid = 1'b1;
        mem_write = 1'b1;
        mem_addr  = l2v_addr_q;
      end
      S_WB: if (!l2_hit) begin
        mem_valid = 1'b1;
        mem_write = 1'b1;
        mem_addr  = l1v_addr_q;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st          <= S_IDLE;
      wr_q        <= 1'b0;
      addr_q      <= '0;
      ev1_q       <= EV_NONE;
      ev2_q       <= EV_NONE;
      l2v_addr_q  <= '0;
      l2v_evict_q <= 1'b0;
      l2v_dirty_q <= 1'b0;
      sub_q       <= '0;
      l1v_addr_q  <= '0;
    end else begin
      case (st)
        S_IDLE: if (req_valid) begin
          wr_q   <= req_write;
          addr_q <= req_addr;
          st     <= S_L1;
        end
        S_L1: begin
          if (l1_hit) begin
            ev1_q <= wr_q ? EV_WR_HIT : EV_RD_HIT;
            ev2_q <= EV_NONE;
            st    <= S_DONE;
          end else begin
            ev1_q <= wr_q ? EV_WR_MISS : EV_RD_MISS;
            st    <= wr_q ? S_L2WR : S_L2RD;
          end
        end
        S_L2WR: begin
          ev2_q <= l2_hit ? EV_WR_HIT : EV_WR_MISS;
          st    <= S_DONE;
        end
        S_L2RD: begin
          if (l2_hit) begin
            ev2_q <= EV_RD_HIT;
            st    <= S_L1FILL;
          end else begin
            ev2_q       <= EV_RD_MISS;
            l2v_addr_q  <= l2_vic_addr;
            l2v_evict_q <= l2_vic_valid;
            l2v_dirty_q <= l2_vic_dirty;
            sub_q       <= '0;
            st          <= l2_vic_valid ? S_INV : S_L2FILL;
          end
        end
        S_INV: begin
          if (l1_hit_dirty) l2v_dirty_q <= 1'b1;
          if (sub_q == SW'(SUB - 1)) st <= S_L2FILL;
          else sub_q <= sub_q + 1'b1;
        end
        S_L2FILL: st <= S_L1FILL;
        S_L1FILL: begin
          if (l1_vic_dirty) begin
            l1v_addr_q <= l1_vic_addr;
            st         <= S_WB;
          end else begin
            st <= S_DONE;
          end
        end
        S_WB:   st <= S_DONE;
        S_DONE: st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  assign req_ready  = (st == S_IDLE);
  assign resp_valid = (st == S_DONE);
  assign resp_l1    = ev1_q;
  assign resp_l2    = ev2_q;

  AST_RESP_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |=> !resp_valid); // R1
  AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready); // R1
  AST_L1_HIT_L2_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && (resp_l1 == EV_RD_HIT || resp_l1 == EV_WR_HIT)) |-> (resp_l2 == EV_NONE)); // R2
  AST_VICTIM_IN_L2: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_WB) |-> l2_hit); // R7
endmodule

// File: tb/cache_seq_tb.sv
module cache_seq_tb;
  localparam int AW = 32;
  localparam int L1S = 4, L1W = 2, L1B = 4;
  localparam int L2S = 8, L2W = 4, L2B = 8;
  localparam int SUB = L2B / L1B;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic          req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic          resp_valid;
  logic [2:0]    resp_l1, resp_l2;
  logic          mem_valid, mem_write;
  logic [AW-1:0] mem_addr;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  cache_seq #(.AW(AW), .L1_SETS(L1S), .L1_WAYS(L1W), .L1_BLK(L1B),
              .L2_SETS(L2S), .L2_WAYS(L2W), .L2_BLK(L2B)) u_dut (
    .clk, .rst_n, .req_valid, .req_ready, .req_write, .req_addr,
    .resp_valid, .resp_l1, .resp_l2, .mem_valid, .mem_write, .mem_addr
  );

  // reference state
  int m1_tag [L1S][L1W]; bit m1_v [L1S][L1W]; bit m1_d [L1S][L1W]; int m1_rr [L1S];
  int m2_tag [L2S][L2W]; bit m2_v [L2S][L2W]; bit m2_d [L2S][L2W]; int m2_rr [L2S];

  task automatic chk(input bit ok, input string rq, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", rq, what, act, exp);
    end
  endtask

  task automatic model_clear();
    for (int s = 0; s < L1S; s++) begin
      m1_rr[s] = 0;
      for (int w = 0; w < L1W; w++) begin m1_v[s][w] = 0; m1_d[s][w] = 0; m1_tag[s][w] = 0; end
    end
    for (int s = 0; s < L2S; s++) begin
      m2_rr[s] = 0;
      for (int w = 0; w < L2W; w++) begin m2_v[s][w] = 0; m2_d[s][w] = 0; m2_tag[s][w] = 0; end
    end
  endtask

  function automatic int l1_find(int blk);
    for (int w = 0; w < L1W; w++)
      if (m1_v[blk % L1S][w] && m1_tag[blk % L1S][w] == blk) return w;
    return -1;
  endfunction

  function automatic int l2_find(int blk);
    for (int w = 0; w < L2W; w++)
      if (m2_v[blk % L2S][w] && m2_tag[blk % L2S][w] == blk) return w;
    return -1;
  endfunction

  function automatic int l1_vic(int s);
    for (int w = 0; w < L1W; w++) if (!m1_v[s][w]) return w;
    return m1_rr[s];
  endfunction

  function automatic int l2_vic(int s);
    for (int w = 0; w < L2W; w++) if (!m2_v[s][w]) return w;
    return m2_rr[s];
  endfunction

  task automatic model_access(input bit w, input int a, output int e1, output int e2,
                              output int lat, output int mrd, output int mwr, output int faddr);
    int b1, s1, b2, s2, h1, h2, v, vb, x, ed;
    b1 = a / L1B; s1 = b1 % L1S; b2 = a / L2B; s2 = b2 % L2S;
    mrd = 0; mwr = 0; faddr = 0; e2 = 0;
    h1 = l1_find(b1);
    if (h1 >= 0) begin
      e1 = w ? 3 : 1; lat = 1;
      if (w) m1_d[s1][h1] = 1;
      return;
    end
    if (w) begin
      e1 = 4; lat = 2;
      h2 = l2_find(b2);
      if (h2 >= 0) begin e2 = 3; m2_d[s2][h2] = 1; end
      else begin e2 = 4; mwr = 1; end
      return;
    end
    e1 = 2; lat = 2;
    h2 = l2_find(b2);
    if (h2 >= 0) e2 = 1;
    else begin
      e2 = 2; mrd = 1; faddr = b2 * L2B;
      v = l2_vic(s2);
      if (m2_v[s2][v]) begin
        ed = m2_d[s2][v]; vb = m2_tag[s2][v];
        for (int k = 0; k < SUB; k++) begin
          x = l1_find(vb * SUB + k);
          if (x >= 0) begin
            if (m1_d[(vb * SUB + k) % L1S][x]) ed = 1;
            m1_v[(vb * SUB + k) % L1S][x] = 0;
            m1_d[(vb * SUB + k) % L1S][x] = 0;
          end
        end
        lat += SUB;
        if (ed != 0) mwr++;
        m2_rr[s2] = (m2_rr[s2] + 1) % L2W;
      end
      m2_v[s2][v] = 1; m2_d[s2][v] = 0; m2_tag[s2][v] = b2;
      lat += 1;
    end
    lat += 1;
    v = l1_vic(s1);
    if (m1_v[s1][v]) begin
      if (m1_d[s1][v]) begin
        lat += 1;
        vb = (m1_tag[s1][v] * L1B) / L2B;
        x = l2_find(vb);
        if (x >= 0) m2_d[vb % L2S][x] = 1;
        else mwr++;
      end
      m1_rr[s1] = (m1_rr[s1] + 1) % L1W;
    end
    m1_v[s1][v] = 1; m1_d[s1][v] = 0; m1_tag[s1][v] = b1;
  endtask

  int last_mwr;

  // h1/h2 < 0: no hand-computed pair for this access
  task automatic do_acc(input bit w, input int a, input string rq, input int h1, input int h2);
    int e1, e2, lat, mrd, mwr, fa, n, dr, dw, da;
    bit busy_ok;
    model_access(w, a, e1, e2, lat, mrd, mwr, fa);
    @(negedge clk);
    chk(req_ready == 1'b1, "R1", "ready idle", int'(req_ready), 1);
    req_valid = 1'b1; req_write = w; req_addr = AW'(a);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    n = 0; dr = 0; dw = 0; da = 0; busy_ok = 1;
    while (!resp_valid && n < 100) begin
      if (req_ready) busy_ok = 0;
      if (mem_valid) begin
        if (mem_write) dw++;
        else begin dr++; da = int'(mem_addr); end
      end
      @(posedge clk);
      @(negedge clk);
      n++;
    end
    if (req_ready) busy_ok = 0;
    chk(busy_ok, "R1", "ready low while busy", 0, 0);
    chk(n == lat, "R8", "latency", n, lat);
    chk(int'(resp_l1) == e1, rq, "L1 code vs model R2", int'(resp_l1), e1);
    chk(int'(resp_l2) == e2, rq, "L2 code vs model R2", int'(resp_l2), e2);
    if (h1 >= 0) chk(int'(resp_l1) == h1, rq, "L1 code", int'(resp_l1), h1);
    if (h2 >= 0) chk(int'(resp_l2) == h2, rq, "L2 code", int'(resp_l2), h2);
    chk(dr == mrd, "R3", "memory fetches", dr, mrd);
    if (mrd == 1) chk(da == fa, "R3", "fetch address", da, fa);
    chk(dw == mwr, "R4 R6 R7", "memory writes", dw, mwr);
    last_mwr = dw;
    @(negedge clk);
    chk(!resp_valid && req_ready, "R1", "one-cycle response", int'(resp_valid), 0);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    req_valid = 1'b0;
    model_clear();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int x;
    do_reset();
    chk(req_ready && !resp_valid && !mem_valid, "R1", "reset state", int'(req_ready), 1);

    // R3 / R2 / R4 directed
    do_acc(0, 32'h000, "R3", 2, 2);
    do_acc(0, 32'h001, "R2", 1, 0);
    do_acc(1, 32'h000, "R4", 3, 0);
    do_acc(1, 32'h400, "R4", 4, 4);
    do_acc(0, 32'h400, "R4", 2, 2);
    do_acc(1, 32'h404, "R4", 4, 3);

    // R6: dirty L1 victim written back into L2
    do_reset();
    do_acc(0, 32'h000, "R6", 2, 2);
    do_acc(1, 32'h000, "R6", 3, 0);
    do_acc(0, 32'h010, "R5", 2, 2);
    do_acc(0, 32'h020, "R6", 2, 2);
    do_acc(0, 32'h030, "R5", 2, 2);
    do_acc(0, 32'h020, "R5", 1, 0);

    // R7: L2 eviction invalidates covering L1 lines, dirty merged
    do_reset();
    do_acc(0, 32'h004, "R7", 2, 2);
    do_acc(1, 32'h004, "R7", 3, 0);
    do_acc(0, 32'h040, "R7", 2, 2);
    do_acc(0, 32'h080, "R7", 2, 2);
    do_acc(0, 32'h0C0, "R7", 2, 2);
    do_acc(0, 32'h100, "R7", 2, 2);
    chk(last_mwr == 1, "R7", "merged writeback", last_mwr, 1);
    do_acc(0, 32'h004, "R7", 2, 2);

    // R5 sweep: pseudo-random accesses over a 1 KiB window
    do_reset();
    x = 32'h1234_5677;
    for (int i = 0; i < 3000; i++) begin
      x = x ^ (x << 13);
      x = x ^ (x >>> 17) & 32'h0000_7FFF;
      x = x ^ (x << 5);
      do_acc(x[20], (x >> 4) & 32'h3FF, "R5", -1, -1);
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule